// File: doc/BRIEF.md
# Dual-Lane Serial Read Controller

This block sits on the host side of a multi-channel sampling converter and pulls its eight 16-bit conversion results over a serial link. When the converter's busy line falls, the controller drops chip select and generates a serial clock from the system clock. On every falling edge of that clock it captures one bit from each active data lane. In dual-lane mode, lane A carries channels 0 to 3 and lane B carries channels 4 to 7, so both are read in 64 serial clocks. In single-lane mode, all eight channels come out of lane A in 128 clocks.

Each completed word is tagged with its channel number and placed in a small result queue. The queue drains through a valid/ready port. If the queue cannot take the word that the next falling edge would complete, the controller holds the serial clock high and waits. The converter's first-data flag is checked at two points: it must be high at the first falling edge, and it must be low after the sixteenth falling edge. A flag seen at the wrong level on either check sets a sticky alignment error.

Top module: `sread_ctrl`

## Requirements
- R1: After reset, chip select is high (inactive), the serial clock is high, result valid is low and the alignment error is low.
- R2: A read frame starts only on a falling edge of busy, i.e. busy sampled high in one cycle and low in the next. Chip select then goes low on the following clock edge. Busy held steadily high or low never starts a frame.
- R3: The serial clock is high when idle. While chip select is low, every high phase and every low phase of the serial clock lasts at least HALF_PERIOD system clocks. This includes the first high phase after chip select falls.
- R4: Data is captured on each serial clock falling edge, 16 bits per word, most significant bit first.
- R5: In dual-lane mode the k-th word of lane A is channel k and the k-th word of lane B is channel k+4 (k = 0..3). Channel tags are 0-based on a 3-bit field. The pair is queued lane A first, giving the output order 0,4,1,5,2,6,3,7.
- R6: A frame contains exactly 64 serial clock falling edges in dual-lane mode and 128 in single-lane mode. Chip select returns high together with the serial clock rising edge that follows the last falling edge.
- R7: In single-lane mode, lane A delivers channels 0 to 7 in order and the value on lane B has no effect on any result.
- R8: While result valid is high and ready is low, the result data and channel tag hold steady. A word is transferred on each clock edge where valid and ready are both high.
- R9: No word is ever lost. With a 4-entry queue held full in dual-lane mode, the serial clock stops high after its 47th falling edge and resumes once space frees up.
- R10: The alignment error is set in either of two cases: the first-data flag is low at the first falling edge of a frame, or it is high at the rising edge that follows the 16th falling edge. Once set, it stays set until reset, and later good frames still deliver correct data.
- R11: A busy falling edge seen while a frame is in progress is ignored; it neither restarts the frame nor queues a second one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_i | input | 1 | Converter busy; its falling edge starts a read |
| first_flag_i | input | 1 | Converter first-data flag |
| lane_a_i | input | 1 | Serial data lane A |
| lane_b_i | input | 1 | Serial data lane B (unused in single-lane mode) |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| res_valid_o | output | 1 | Result word available |
| res_ready_i | input | 1 | Consumer accepts the result |
| res_data_o | output | WORD_W | Result word |
| res_chan_o | output | clog2(NUM_CH) | 0-based channel tag of the result |
| align_err_o | output | 1 | Sticky alignment error |

## Verification
Two events can land in the same cycle: the consumer popping the queue head, and the engine deciding whether the next completing falling edge may go ahead. The bench provokes this by holding ready low until the serial clock stalls with the queue full. It then releases ready so that pops and the resumed shifting overlap. It judges the overlap by the exact stall point (47 falling edges), steady head data during the stall, and the complete 0,4,1,5,2,6,3,7 sequence afterwards. A second overlap comes from a busy falling edge injected in mid-frame; it must leave the frame at 64 edges with a single chip-select assertion.

// File: rtl/sread_pkg.sv
package sread_pkg;

  // Frame engine state
  typedef enum logic {
    RD_IDLE  = 1'b0,
    RD_SHIFT = 1'b1
  } rd_state_e;

endpackage

// File: rtl/sread_sclk_gen.sv
module sread_sclk_gen #(
  parameter int HALF_PERIOD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic hold,
  output logic sclk_o,
  output logic fall_now_o,
  output logic rise_now_o
);
  localparam int CW = ($clog2(HALF_PERIOD) > 0) ? $clog2(HALF_PERIOD) : 1;
  localparam int LW = $clog2(HALF_PERIOD + 1);

  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end     = (cnt == CW'(HALF_PERIOD - 1));
  // A falling edge may be blocked (hold); a rising edge never is.
  assign fall_now_o = run && at_end && sclk_o && !hold;
  assign rise_now_o = run && at_end && !sclk_o;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      sclk_o <= 1'b1;
      cnt    <= '0;
    end else if (fall_now_o || rise_now_o) begin
      sclk_o <= ~sclk_o;
      cnt    <= '0;
    end else if (!at_end) begin
      cnt <= cnt + 1'b1;
    end
  end

  // Checker: measure how long the pin really stays at each level.
  logic          sclk_prev;
  logic [LW-1:0] phase_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b1;
      phase_len <= LW'(HALF_PERIOD);
    end else begin
      sclk_prev <= sclk_o;
      if (sclk_o != sclk_prev)
        phase_len <= LW'(1);
      else if (phase_len != LW'(HALF_PERIOD))
        phase_len <= phase_len + 1'b1;
    end
  end

  // R3: no phase of the serial clock is shorter than HALF_PERIOD cycles
  a_r3_min_phase: assert property (@(posedge clk) disable iff (rst)
    (sclk_o != sclk_prev) |-> (phase_len >= LW'(HALF_PERIOD)));

endmodule

// File: rtl/sread_lane_shift.sv
module sread_lane_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              din,
  output logic [WORD_W-1:0] word_o
);
  // MSB arrives first, so shift toward the top.
  always_ff @(posedge clk) begin
    if (rst)
      word_o <= '0;
    else if (shift_en)
      word_o <= {word_o[WORD_W-2:0], din};
  end

endmodule

// File: rtl/sread_queue.sv
module sread_queue #(
  parameter int W     = 19,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  input  logic                       rd_ready,
  output logic                       rd_valid,
  output logic [W-1:0]               rd_data,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int AW = ($clog2(DEPTH) > 0) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp;
  logic [AW-1:0] rp;
  logic [CW-1:0] cnt;
  logic          pop;

  assign rd_valid = (cnt != '0);
  assign rd_data  = mem[rp];
  assign pop      = rd_valid && rd_ready;
  assign count_o  = cnt;

  always_ff @(posedge clk) begin
    if (wr_en)
      mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en)
        wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)
        rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(wr_en) - CW'(pop);
    end
  end

  // R9: the engine never writes into a full queue
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (cnt < CW'(DEPTH)));

  // R8: a stalled head does not move
  a_r8_head_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

endmodule

// File: rtl/sread_ctrl.sv
module sread_ctrl
  import sread_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int NUM_CH      = 8,
  parameter int HALF_PERIOD = 2,
  parameter bit DUAL_LANE   = 1'b1,
  parameter int QUEUE_DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      busy_i,
  input  logic                      first_flag_i,
  input  logic                      lane_a_i,
  input  logic                      lane_b_i,
  output logic                      cs_n_o,
  output logic                      sclk_o,
  output logic                      res_valid_o,
  input  logic                      res_ready_i,
  output logic [WORD_W-1:0]         res_data_o,
  output logic [$clog2(NUM_CH)-1:0] res_chan_o,
  output logic                      align_err_o
);
  localparam int LANES         = DUAL_LANE ? 2 : 1;
  localparam int CH_PER_LANE   = NUM_CH / LANES;
  localparam int BITS_PER_LANE = CH_PER_LANE * WORD_W;
  localparam int CH_W          = $clog2(NUM_CH);
  localparam int BIT_W         = $clog2(BITS_PER_LANE + 1);
  localparam int POS_W         = $clog2(WORD_W);
  localparam int WIDX_W        = (CH_PER_LANE > 1) ? $clog2(CH_PER_LANE) : 1;
  localparam int ENTRY_W       = CH_W + WORD_W;
  localparam int CNT_W         = $clog2(QUEUE_DEPTH + 1);

  rd_state_e          state;
  logic               busy_q;
  logic               busy_fall;
  logic [BIT_W-1:0]   bit_cnt;
  logic               all_done;
  logic               word_ends_next;
  logic               queue_short;
  logic               gen_hold;
  logic               fall_now;
  logic               rise_now;
  logic [CNT_W-1:0]   q_count;
  logic               push_busy;
  logic               push_lane;
  logic [WIDX_W-1:0]  widx;
  logic [WORD_W-1:0]  push_word;
  logic [CH_W-1:0]    push_chan;
  logic [ENTRY_W-1:0] head;
  logic [WORD_W-1:0]  lane_words [LANES];
  logic               unused_lane_b;

  assign unused_lane_b  = lane_b_i;
  assign busy_fall      = busy_q && !busy_i;
  assign all_done       = (bit_cnt == BIT_W'(BITS_PER_LANE));
  assign word_ends_next = (bit_cnt[POS_W-1:0] == POS_W'(WORD_W - 1));
  assign queue_short    = (q_count > CNT_W'(QUEUE_DEPTH - LANES));
  assign gen_hold       = all_done || (word_ends_next && queue_short);

  sread_sclk_gen #(.HALF_PERIOD(HALF_PERIOD)) u_sclk (
    .clk        (clk),
    .rst        (rst),
    .run        (state == RD_SHIFT),
    .hold       (gen_hold),
    .sclk_o     (sclk_o),
    .fall_now_o (fall_now),
    .rise_now_o (rise_now)
  );

  // One shift register per active lane.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l == 0) begin : g_a
      sread_lane_shift #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst(rst), .shift_en(fall_now), .din(lane_a_i),
        .word_o(lane_words[l]));
    end else begin : g_b
      sread_lane_shift #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst(rst), .shift_en(fall_now), .din(lane_b_i),
        .word_o(lane_words[l]));
    end
  end

  if (LANES == 2) begin : g_mux2
    assign push_word = push_lane ? lane_words[1] : lane_words[0];
  end else begin : g_mux1
    assign push_word = lane_words[0];
  end

  assign push_chan = CH_W'(push_lane) * CH_W'(CH_PER_LANE) + CH_W'(widx);

  // Frame sequencing and alignment supervision.
  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= RD_IDLE;
      cs_n_o      <= 1'b1;
      busy_q      <= 1'b0;
      bit_cnt     <= '0;
      align_err_o <= 1'b0;
    end else begin
      busy_q <= busy_i;
      case (state)
        RD_IDLE: begin
          if (busy_fall) begin
            state   <= RD_SHIFT;
            cs_n_o  <= 1'b0;
            bit_cnt <= '0;
          end
        end
        default: begin
          if (fall_now)
            bit_cnt <= bit_cnt + 1'b1;
          if (rise_now && all_done) begin
            state  <= RD_IDLE;
            cs_n_o <= 1'b1;
          end
        end
      endcase
      if (fall_now && (bit_cnt == '0) && !first_flag_i)
        align_err_o <= 1'b1;
      if (rise_now && (bit_cnt == BIT_W'(WORD_W)) && first_flag_i)
        align_err_o <= 1'b1;
    end
  end

  // Queue the finished words, one lane per cycle, lane A first.
  always_ff @(posedge clk) begin
    if (rst) begin
      push_busy <= 1'b0;
      push_lane <= 1'b0;
      widx      <= '0;
    end else begin
      if (state == RD_IDLE && busy_fall)
        widx <= '0;
      if (fall_now && word_ends_next) begin
        push_busy <= 1'b1;
        push_lane <= 1'b0;
      end else if (push_busy) begin
        if (push_lane == 1'(LANES - 1)) begin
          push_busy <= 1'b0;
          widx      <= widx + 1'b1;
        end else begin
          push_lane <= push_lane + 1'b1;
        end
      end
    end
  end

  sread_queue #(.W(ENTRY_W), .DEPTH(QUEUE_DEPTH)) u_queue (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (push_busy),
    .wr_data  ({push_chan, push_word}),
    .rd_ready (res_ready_i),
    .rd_valid (res_valid_o),
    .rd_data  (head),
    .count_o  (q_count)
  );

  assign res_chan_o = head[ENTRY_W-1:WORD_W];
  assign res_data_o = head[WORD_W-1:0];

  // R6: while idle the serial clock rests high
  a_r6_idle_sclk_high: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> sclk_o);

  // R10: alignment error is sticky
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
    align_err_o |=> align_err_o);

  // R11: an unfinished frame keeps chip select low
  a_r11_no_restart: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_o && !all_done) |=> !cs_n_o);

  // R2: chip select only falls right after a busy falling edge
  a_r2_start_on_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> ($past(busy_q) && !$past(busy_i)));

endmodule

// File: tb/sread_ctrl_test.sv
module conv_model #(
  parameter bit DUAL = 1'b1
) (
  input  logic        cs_n,
  input  logic        sclk,
  input  logic [15:0] seed,
  input  logic        flag_stuck,
  output logic        lane_a,
  output logic        lane_b,
  output logic        flag
);
  int   bitpos = 0;
  int   falls  = 0;
  logic cs_prev = 1'b1;
  logic sclk_prev = 1'b1;

  function automatic logic [15:0] word_of(input logic [15:0] s, input int ch);
    return s ^ 16'((ch + 1) * 16'h2A5B);
  endfunction

  initial begin
    lane_a = 1'b0;
    lane_b = 1'b0;
    flag   = 1'b0;
  end

  always @(cs_n or sclk) begin
    automatic int          ch;
    automatic int          bi;
    automatic logic [15:0] wa;
    automatic logic [15:0] wb;
    if (cs_prev && !cs_n) begin
      bitpos = 0; falls = 0; flag = 1'b1;
    end else if (!cs_prev && cs_n) begin
      flag = 1'b0;
    end else if (!cs_n && !sclk_prev && sclk) begin
      bitpos = bitpos + 1;
    end else if (!cs_n && sclk_prev && !sclk) begin
      falls = falls + 1;
      if (falls == 16 && !flag_stuck) flag = 1'b0;
    end
    cs_prev   = cs_n;
    sclk_prev = sclk;
    ch = bitpos / 16;
    bi = 15 - (bitpos % 16);
    wa = word_of(seed, ch);
    wb = word_of(seed, ch + 4);
    lane_a = (ch < 8) ? wa[bi] : 1'b0;
    lane_b = DUAL ? wb[bi] : (bitpos[0] ^ wa[bi]);
  end
endmodule

module sread_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // dual-lane device under test
  logic        busy_d = 1'b0, ready_d = 1'b1, stuck_d = 1'b0;
  logic [15:0] seed_d = 16'h0000;
  logic        cs_n_d, sclk_d, la_d, lb_d, flag_d, valid_d, err_d;
  logic [15:0] data_d;
  logic [2:0]  chan_d;

  // single-lane device under test
  logic        busy_s = 1'b0;
  logic [15:0] seed_s = 16'h0000;
  logic        cs_n_s, sclk_s, la_s, lb_s, flag_s, valid_s, err_s;
  logic [15:0] data_s;
  logic [2:0]  chan_s;

  sread_ctrl #(.DUAL_LANE(1'b1)) uut (
    .clk(clk), .rst(rst), .busy_i(busy_d), .first_flag_i(flag_d),
    .lane_a_i(la_d), .lane_b_i(lb_d), .cs_n_o(cs_n_d), .sclk_o(sclk_d),
    .res_valid_o(valid_d), .res_ready_i(ready_d), .res_data_o(data_d),
    .res_chan_o(chan_d), .align_err_o(err_d));

  sread_ctrl #(.DUAL_LANE(1'b0)) uut_single (
    .clk(clk), .rst(rst), .busy_i(busy_s), .first_flag_i(flag_s),
    .lane_a_i(la_s), .lane_b_i(lb_s), .cs_n_o(cs_n_s), .sclk_o(sclk_s),
    .res_valid_o(valid_s), .res_ready_i(1'b1), .res_data_o(data_s),
    .res_chan_o(chan_s), .align_err_o(err_s));

  conv_model #(.DUAL(1'b1)) dev_d (.cs_n(cs_n_d), .sclk(sclk_d), .seed(seed_d),
    .flag_stuck(stuck_d), .lane_a(la_d), .lane_b(lb_d), .flag(flag_d));
  conv_model #(.DUAL(1'b0)) dev_s (.cs_n(cs_n_s), .sclk(sclk_s), .seed(seed_s),
    .flag_stuck(1'b0), .lane_a(la_s), .lane_b(lb_s), .flag(flag_s));

  int n_chk = 0;
  int n_bad = 0;

  function automatic logic [15:0] word_of(input logic [15:0] s, input int ch);
    return s ^ 16'((ch + 1) * 16'h2A5B);
  endfunction

  // monitors, sampled on the falling system clock edge
  logic [15:0] got_data_d [16];
  logic [2:0]  got_chan_d [16];
  int n_got_d = 0, falls_d = 0, starts_d = 0, run_d = 0, min_run_d = 1000;
  logic cs_pm_d = 1'b1, sclk_pm_d = 1'b1;

  logic [15:0] got_data_s [16];
  logic [2:0]  got_chan_s [16];
  int n_got_s = 0, falls_s = 0, starts_s = 0;
  logic sclk_pm_s = 1'b1, cs_pm_s = 1'b1;

  always @(negedge clk) begin
    if (valid_d && ready_d && n_got_d < 16) begin
      got_data_d[n_got_d] = data_d; got_chan_d[n_got_d] = chan_d; n_got_d++;
    end
    if (cs_pm_d && !cs_n_d) begin
      starts_d++; run_d = 1;
    end else if (!cs_n_d) begin
      if (sclk_d != sclk_pm_d) begin
        if (run_d < min_run_d) min_run_d = run_d;
        run_d = 1;
      end else run_d++;
    end
    if (sclk_pm_d && !sclk_d) falls_d++;
    cs_pm_d = cs_n_d; sclk_pm_d = sclk_d;

    if (valid_s && n_got_s < 16) begin
      got_data_s[n_got_s] = data_s; got_chan_s[n_got_s] = chan_s; n_got_s++;
    end
    if (cs_pm_s && !cs_n_s) starts_s++;
    if (sclk_pm_s && !sclk_s) falls_s++;
    cs_pm_s = cs_n_s; sclk_pm_s = sclk_s;
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_d();
    n_got_d = 0; falls_d = 0; starts_d = 0; min_run_d = 1000;
  endtask

  task automatic wait_dual();
    int guard = 0;
    while (cs_n_d && guard < 100) begin tick(); guard++; end
    while (!cs_n_d && guard < 5000) begin tick(); guard++; end
    tick(12);
  endtask

  task automatic pulse_busy_d();
    busy_d = 1'b1; tick(3); busy_d = 1'b0; tick();
  endtask

  task automatic check_frame_d(input string tag);
    check(n_got_d == 8, {tag, " R5 count"}, n_got_d, 8);
    for (int i = 0; i < 8 && i < n_got_d; i++) begin
      automatic int ch = (i % 2) * 4 + i / 2;
      check(got_chan_d[i] == 3'(ch), {tag, " R5 chan"}, got_chan_d[i], ch);
      check(got_data_d[i] == word_of(seed_d, ch), {tag, " R4 data"},
            got_data_d[i], word_of(seed_d, ch));
    end
  endtask

  task automatic t_reset();
    check(cs_n_d == 1'b1 && cs_n_s == 1'b1, "R1 cs idle", cs_n_d, 1);
    check(sclk_d == 1'b1 && sclk_s == 1'b1, "R1 sclk idle", sclk_d, 1);
    check(valid_d == 1'b0 && valid_s == 1'b0, "R1 valid", valid_d, 0);
    check(err_d == 1'b0 && err_s == 1'b0, "R1 err", err_d, 0);
  endtask

  task automatic t_start_and_basic();
    clear_d();
    seed_d = 16'h1234;
    busy_d = 1'b1; tick(20);
    check(starts_d == 0 && cs_n_d == 1'b1, "R2 steady busy high", starts_d, 0);
    busy_d = 1'b0; tick(2);
    check(cs_n_d == 1'b0, "R2 start on fall", cs_n_d, 0);
    wait_dual();
    check(starts_d == 1, "R2 one frame", starts_d, 1);
    check(falls_d == 64, "R6 dual falls", falls_d, 64);
    check(cs_n_d == 1'b1 && sclk_d == 1'b1, "R6 release", cs_n_d, 1);
    check(min_run_d >= 2, "R3 min phase", min_run_d, 2);
    check(err_d == 1'b0, "R10 no false error", err_d, 0);
    check_frame_d("basic");
  endtask

  task automatic t_second_pattern();
    clear_d();
    seed_d = 16'hFFFF;
    pulse_busy_d();
    wait_dual();
    check(falls_d == 64, "R6 dual falls 2", falls_d, 64);
    check_frame_d("pattern2");
  endtask

  task automatic t_backpressure();
    logic [15:0] first;
    clear_d();
    seed_d = 16'hA5C3;
    ready_d = 1'b0;
    pulse_busy_d();
    tick(400);
    check(cs_n_d == 1'b0, "R9 frame still open", cs_n_d, 0);
    check(falls_d == 47, "R9 stall point", falls_d, 47);
    check(sclk_d == 1'b1, "R9 stalled high", sclk_d, 1);
    first = data_d;
    check(valid_d && chan_d == 3'd0 && first == word_of(seed_d, 0),
          "R8 head", first, word_of(seed_d, 0));
    tick(20);
    check(data_d == first && valid_d, "R8 head steady", data_d, first);
    ready_d = 1'b1;
    wait_dual();
    check(falls_d == 64, "R9 resumed falls", falls_d, 64);
    check_frame_d("backpressure");
  endtask

  task automatic t_busy_mid();
    clear_d();
    seed_d = 16'h0F0F;
    pulse_busy_d();
    tick(30);
    busy_d = 1'b1; tick(2); busy_d = 1'b0;
    wait_dual();
    tick(40);
    check(starts_d == 1, "R11 no restart", starts_d, 1);
    check(falls_d == 64, "R11 falls", falls_d, 64);
    check_frame_d("busy_mid");
  endtask

  task automatic t_align();
    clear_d();
    seed_d = 16'h3C3C;
    stuck_d = 1'b1;
    pulse_busy_d();
    wait_dual();
    check(err_d == 1'b1, "R10 error raised", err_d, 1);
    stuck_d = 1'b0;
    clear_d();
    seed_d = 16'h7E81;
    pulse_busy_d();
    wait_dual();
    check(err_d == 1'b1, "R10 sticky", err_d, 1);
    check_frame_d("after_err");
    rst = 1'b1; tick(3); rst = 1'b0; tick();
    check(err_d == 1'b0, "R1 reset clears err", err_d, 0);
  endtask

  task automatic t_single();
    int guard = 0;
    n_got_s = 0; falls_s = 0; starts_s = 0;
    seed_s = 16'h5AA5;
    busy_s = 1'b1; tick(3); busy_s = 1'b0; tick();
    while (cs_n_s && guard < 100) begin tick(); guard++; end
    while (!cs_n_s && guard < 5000) begin tick(); guard++; end
    tick(12);
    check(falls_s == 128, "R6 single falls", falls_s, 128);
    check(n_got_s == 8, "R7 count", n_got_s, 8);
    for (int i = 0; i < 8 && i < n_got_s; i++) begin
      check(got_chan_s[i] == 3'(i), "R7 chan", got_chan_s[i], i);
      check(got_data_s[i] == word_of(seed_s, i), "R7 data",
            got_data_s[i], word_of(seed_s, i));
    end
    check(err_s == 1'b0, "R10 single no error", err_s, 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1;
    tick(4);
    rst = 1'b0;
    tick(2);
    t_reset();
    t_start_and_basic();
    t_second_pattern();
    t_backpressure();
    t_busy_mid();
    t_align();
    t_single();
    summary();
    $finish;
  end

endmodule